// File: doc/BRIEF.md
# Indexed-Absolute Multi-Cycle Instruction Sequencer

This block is the step generator and byte-wide datapath of a small accumulator machine that runs one instruction at a time. Each instruction moves through a fixed chain of numbered steps, and a new opcode can only be fetched in step 0. Memory is reached through a single port. The address and write strobe are registered state. The read byte is taken at the clock edge that ends the cycle in which its address is shown.

The block handles three opcodes. Two of them use indexed absolute addressing, where a 16-bit base is taken from the instruction stream and the index register X is added to its low byte. An add that reads memory skips the high-byte correction step when the index add gives no page carry. A memory increment always runs all seven steps, and the correction is applied inside step 4 only when it is needed. When an add finishes, its accumulator update is done during the opcode fetch of the next instruction. Any other opcode takes two cycles and has no effect.

Top module: `idx_seq_core`

## Requirements
- R1: While rst_n is low, mem_we is 0, mem_addr is 0x0000, fetch_o is 1, and acc_o and carry_o are 0. After rst_n rises, the block stays in reset for two more rising edges. The cycle after the second edge is the first opcode fetch, and it is taken from 0x0000.
- R2: In step 0, mem_addr is the program counter, fetch_o is 1 (in no other step), the read byte becomes the opcode, and the program counter then advances by one.
- R3: Step 1 always reads at the program counter. For an opcode other than 0x61, 0x62 or 0x63, the program counter is not advanced and the next cycle fetches an opcode from that same address, so the instruction takes two cycles and changes no state.
- R4: Opcode 0x63 loads X with the byte read in step 1, advances the program counter, and takes two cycles.
- R5: For 0x61 and 0x62, step 1 reads the base low byte and step 2 reads the base high byte, and each advances the program counter. Step 3 reads at {high byte, low 8 bits of low byte + X}.
- R6: For 0x61 with no carry out of the low-byte add, the instruction ends after step 3 (four cycles). The following step 0 performs {carry, acc} = acc + data + carry, and the new values are visible from the cycle after that fetch.
- R7: For 0x61 with a carry out of the low-byte add, a step 4 reads at {high byte + 1, low sum}. The instruction takes five cycles and then completes as in R6 using the step 4 byte.
- R8: Opcode 0x62 always runs steps 0 to 6. Step 4 reads at {high byte, or high byte + 1 when a page carry occurred, low sum}. Step 5 writes the byte read in step 4 back unchanged to that address. Step 6 writes that byte plus one (mod 256) to the same address. acc_o and carry_o do not change.
- R9: mem_we is 1 only in steps 5 and 6 of opcode 0x62.
- R10: A new opcode fetch follows only the last step of the current sequence. Only the tail of a sequence is ever dropped, never a middle step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| mem_addr | output | 16 | Memory address for this cycle |
| mem_rdata | input | 8 | Byte read at mem_addr, captured at the closing edge |
| mem_wdata | output | 8 | Byte to write when mem_we is 1 |
| mem_we | output | 1 | Write strobe |
| fetch_o | output | 1 | High in opcode-fetch steps |
| acc_o | output | 8 | Accumulator |
| carry_o | output | 1 | Carry flag |

## Verification
The hardest conditions to reach are the page-carry cases, because they depend on X, which can only be set by running an earlier instruction. The program first loads X with a small value and later with 0xF0. Each memory instruction is then run once with a base that keeps the low-byte sum within its page and once with a base that carries out. The scoreboard compares the address, strobe and write data of every cycle, so both the wrong-page read in step 3 and the corrected read in step 4 are checked. Overflowing the accumulator with the carried add makes the carry flag feed into the last add.

// File: rtl/idx_seq_pkg.sv
package idx_seq_pkg;

  typedef enum logic [2:0] {
    ST0 = 3'd0, ST1 = 3'd1, ST2 = 3'd2, ST3 = 3'd3,
    ST4 = 3'd4, ST5 = 3'd5, ST6 = 3'd6
  } step_e;

  typedef enum logic [1:0] {
    K_NOP = 2'd0, K_LDX = 2'd1, K_ADD = 2'd2, K_INC = 2'd3
  } kind_e;

  localparam logic [7:0] OPC_ADD = 8'h61;
  localparam logic [7:0] OPC_INC = 8'h62;
  localparam logic [7:0] OPC_LDX = 8'h63;

  function automatic kind_e op_kind(input logic [7:0] op);
    case (op)
      OPC_ADD: op_kind = K_ADD;
      OPC_INC: op_kind = K_INC;
      OPC_LDX: op_kind = K_LDX;
      default: op_kind = K_NOP;
    endcase
  endfunction

endpackage

// File: rtl/idx_seq_step.sv
module idx_seq_step
  import idx_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  kind_e kind,
  input  logic  page_cy,
  output step_e step_q,
  output logic  add_done
);

  step_e step_d;

  always_comb begin
    step_d = ST0;
    case (step_q)
      ST0: step_d = ST1;
      ST1: step_d = (kind == K_ADD || kind == K_INC) ? ST2 : ST0;
      ST2: step_d = ST3;
      ST3: step_d = (kind == K_ADD && !page_cy) ? ST0 : ST4;
      ST4: step_d = (kind == K_INC) ? ST5 : ST0;
      ST5: step_d = ST6;
      ST6: step_d = ST0;
      default: step_d = ST0;
    endcase
  end

  // an add sequence ends when it is leaving a non-fetch step back to step 0
  assign add_done = (kind == K_ADD) && (step_q != ST0) && (step_d == ST0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST0;
    else        step_q <= step_d;
  end

endmodule

// File: rtl/idx_seq_addr.sv
module idx_seq_addr
  import idx_seq_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  step_e         step,
  input  kind_e         kind,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] x_val,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] pc_q,
  output logic          page_cy
);

  logic [DW-1:0] lo_q, hi_q;
  logic          cy_q;
  logic [DW:0]   idx_sum;
  logic [DW-1:0] hi_inc;
  logic          pc_en, lo_en, hi_en, cy_en;
  logic [AW-1:0] pc_d;
  logic [DW-1:0] lo_d, hi_d;

  assign idx_sum = {1'b0, lo_q} + {1'b0, x_val};
  assign hi_inc  = hi_q + {{(DW-1){1'b0}}, 1'b1};

  always_comb begin
    pc_en = (step == ST0) || (step == ST2) ||
            ((step == ST1) && (kind != K_NOP));
    lo_en = (step == ST1) || (step == ST2);
    hi_en = (step == ST2) || ((step == ST4) && cy_q);
    cy_en = (step == ST2);
    pc_d  = pc_q + {{(AW-1){1'b0}}, 1'b1};
    lo_d  = (step == ST1) ? rdata : idx_sum[DW-1:0];
    hi_d  = (step == ST2) ? rdata : hi_inc;
  end

  always_comb begin
    case (step)
      ST3:      addr = {hi_q, lo_q};
      ST4:      addr = {(cy_q ? hi_inc : hi_q), lo_q};
      ST5, ST6: addr = {hi_q, lo_q};
      default:  addr = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      lo_q <= '0;
      hi_q <= '0;
      cy_q <= 1'b0;
    end else begin
      if (pc_en) pc_q <= pc_d;
      if (lo_en) lo_q <= lo_d;
      if (hi_en) hi_q <= hi_d;
      if (cy_en) cy_q <= idx_sum[DW];
    end
  end

  assign page_cy = cy_q;

endmodule

// File: rtl/idx_seq_data.sv
module idx_seq_data
  import idx_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  step_e         step,
  input  kind_e         kind,
  input  logic          add_done,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] ir_q,
  output logic [DW-1:0] x_q,
  output logic [DW-1:0] d_q,
  output logic [DW-1:0] acc_q,
  output logic          c_q
);

  logic          pend_q, pend_d;
  logic          ir_en, x_en, d_en, acc_en;
  logic [DW-1:0] d_d;
  logic [DW:0]   add_res;

  assign add_res = {1'b0, acc_q} + {1'b0, d_q} + {{DW{1'b0}}, c_q};

  always_comb begin
    ir_en  = (step == ST0);
    x_en   = (step == ST1) && (kind == K_LDX);
    d_en   = (step == ST3) || (step == ST4) || (step == ST5);
    d_d    = (step == ST5) ? d_q + {{(DW-1){1'b0}}, 1'b1} : rdata;
    acc_en = (step == ST0) && pend_q;
    if (step == ST0)   pend_d = 1'b0;
    else if (add_done) pend_d = 1'b1;
    else               pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q   <= '0;
      x_q    <= '0;
      d_q    <= '0;
      acc_q  <= '0;
      c_q    <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (ir_en) ir_q <= rdata;
      if (x_en)  x_q  <= rdata;
      if (d_en)  d_q  <= d_d;
      if (acc_en) begin
        acc_q <= add_res[DW-1:0];
        c_q   <= add_res[DW];
      end
    end
  end

endmodule

// File: rtl/idx_seq_core.sv
module idx_seq_core
  import idx_seq_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          fetch_o,
  output logic [DW-1:0] acc_o,
  output logic          carry_o
);

  logic          rst_s1, rst_sync_n;
  step_e         step_q;
  kind_e         kind;
  logic          page_cy, add_done, c_q;
  logic [DW-1:0] ir_q, x_q, d_q, acc_q;
  logic [AW-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  assign kind = op_kind(ir_q);

  idx_seq_step u_step (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .kind     (kind),
    .page_cy  (page_cy),
    .step_q   (step_q),
    .add_done (add_done)
  );

  idx_seq_addr #(.DW(DW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step    (step_q),
    .kind    (kind),
    .rdata   (mem_rdata),
    .x_val   (x_q),
    .addr    (mem_addr),
    .pc_q    (pc_q),
    .page_cy (page_cy)
  );

  idx_seq_data #(.DW(DW)) u_data (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .step     (step_q),
    .kind     (kind),
    .add_done (add_done),
    .rdata    (mem_rdata),
    .ir_q     (ir_q),
    .x_q      (x_q),
    .d_q      (d_q),
    .acc_q    (acc_q),
    .c_q      (c_q)
  );

  assign mem_wdata = d_q;
  assign mem_we    = (step_q == ST5) || (step_q == ST6);
  assign fetch_o   = (step_q == ST0);
  assign acc_o     = acc_q;
  assign carry_o   = c_q;

endmodule

// File: rtl/idx_seq_chk.sv
module idx_seq_chk
  import idx_seq_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input logic          clk,
  input logic          rst_ok,
  input logic [2:0]    step,
  input logic [1:0]    kind,
  input logic          page_cy,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_we,
  input logic [DW-1:0] acc_o,
  input logic          carry_o
);

  // R9
  we_rmw_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    mem_we |-> (step == 3'd5 || step == 3'd6));

  // R2
  pc_fetch_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && $past(step) == 3'd0) |-> pc == $past(pc) + 1'b1);

  // R5
  hi_addr_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (step == 3'd3) |-> mem_addr[AW-1:DW] == $past(mem_rdata));

  // R6
  add_exit_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(step) == 3'd3 && $past(kind) == 2'(K_ADD) && !$past(page_cy))
      |-> step == 3'd0);

  // R8
  rmw_full_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(step) == 3'd3 && $past(kind) == 2'(K_INC)) |-> step == 3'd4);

  // R8
  rmw_incr_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (step == 3'd6) |-> (mem_we && mem_addr == $past(mem_addr) &&
                        mem_wdata == $past(mem_wdata) + 1'b1));

  // R8
  rmw_acc_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (step != 3'd0 && kind == 2'(K_INC)) |=> ($stable(acc_o) && $stable(carry_o)));

  // R10
  tail_only_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (step == 3'd0 && $past(rst_ok)) |->
      ($past(step) == 3'd1 || $past(step) == 3'd3 ||
       $past(step) == 3'd4 || $past(step) == 3'd6));

endmodule

bind idx_seq_core idx_seq_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .step      (step_q),
  .kind      (kind),
  .page_cy   (page_cy),
  .pc        (pc_q),
  .mem_addr  (mem_addr),
  .mem_rdata (mem_rdata),
  .mem_wdata (mem_wdata),
  .mem_we    (mem_we),
  .acc_o     (acc_o),
  .carry_o   (carry_o)
);

// File: tb/idx_seq_core_bench.sv
module idx_seq_core_bench;

  typedef struct {
    logic [15:0] a;
    logic        we;
    logic [7:0]  wd;
    logic        f;
    logic [7:0]  acc;
    logic        c;
    string       req;
  } cyc_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        fetch_o;
  logic [7:0]  acc_o;
  logic        carry_o;

  int checks = 0;
  int errors = 0;
  bit run = 1'b0;
  bit done = 1'b0;
  logic [7:0] mem [int];
  cyc_t exp_q [$];

  // model state
  logic [15:0] epc;
  logic [7:0]  ex, ea, ed;
  logic        ec, epend;

  always #2.5 clk = ~clk;

  idx_seq_core u_idx_seq_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .fetch_o(fetch_o),
    .acc_o(acc_o), .carry_o(carry_o)
  );

  function automatic logic [7:0] rd(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic we, input logic [7:0] wd,
                      input logic f, input string req);
    cyc_t it;
    it.a = a; it.we = we; it.wd = wd; it.f = f;
    it.acc = ea; it.c = ec; it.req = req;
    exp_q.push_back(it);
  endtask

  // R2 / R6: opcode fetch, finishing any pending add
  task automatic op_fetch();
    push(epc, 1'b0, 8'h00, 1'b1, "R2");
    if (epend) begin
      {ec, ea} = {1'b0, ea} + {1'b0, ed} + {8'h00, ec};
      epend = 1'b0;
    end
    epc++;
  endtask

  task automatic do_nop();
    op_fetch();
    push(epc, 1'b0, 8'h00, 1'b0, "R3");
  endtask

  task automatic do_ldx();
    op_fetch();
    push(epc, 1'b0, 8'h00, 1'b0, "R4");
    ex = rd(epc);
    epc++;
  endtask

  task automatic do_mem(input bit is_inc);
    logic [7:0] lo, hi;
    logic [8:0] s;
    logic [15:0] a4;
    op_fetch();
    lo = rd(epc); push(epc, 1'b0, 8'h00, 1'b0, "R5"); epc++;
    hi = rd(epc); push(epc, 1'b0, 8'h00, 1'b0, "R5"); epc++;
    s = {1'b0, lo} + {1'b0, ex};
    push({hi, s[7:0]}, 1'b0, 8'h00, 1'b0, "R5");
    ed = rd({hi, s[7:0]});
    a4 = {(s[8] ? hi + 8'h01 : hi), s[7:0]};
    if (is_inc) begin
      push(a4, 1'b0, 8'h00, 1'b0, "R8");
      ed = rd(a4);
      push(a4, 1'b1, ed, 1'b0, "R8");
      push(a4, 1'b1, ed + 8'h01, 1'b0, "R8");
    end else begin
      if (s[8]) begin
        push(a4, 1'b0, 8'h00, 1'b0, "R7");
        ed = rd(a4);
      end
      epend = 1'b1;
    end
  endtask

  // memory model: write at the edge, read data settles after it
  initial begin
    mem_rdata = 8'h00;
    forever begin
      logic        w_en;
      logic [15:0] w_a;
      logic [7:0]  w_d;
      @(negedge clk);
      w_en = mem_we; w_a = mem_addr; w_d = mem_wdata;
      @(posedge clk);
      if (w_en === 1'b1) mem[int'(w_a)] = w_d;
      #1;
      mem_rdata = rd(mem_addr);
    end
  end

  // monitor: one expected item per active cycle
  initial begin
    forever begin
      @(negedge clk);
      if (run && exp_q.size() > 0) begin
        cyc_t it;
        bit ok;
        it = exp_q.pop_front();
        ok = (mem_addr === it.a) && (mem_we === it.we) && (fetch_o === it.f) &&
             (acc_o === it.acc) && (carry_o === it.c) &&
             (!it.we || mem_wdata === it.wd);
        check(ok, it.req, "addr/we/wdata/fetch/acc/c",
              {mem_addr, mem_we, mem_wdata, fetch_o, acc_o[5:0]},
              {it.a, it.we, it.wd, it.f, it.acc[5:0]});
        if (!ok)
          $display("      detail acc=%h c=%b expected acc=%h c=%b", acc_o, carry_o, it.acc, it.c);
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R10", "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // program
    mem[32'h0000] = 8'h63; mem[32'h0001] = 8'h05;                       // X = 05
    mem[32'h0002] = 8'h61; mem[32'h0003] = 8'h10; mem[32'h0004] = 8'h20; // add, no carry
    mem[32'h0005] = 8'h63; mem[32'h0006] = 8'hF0;                       // X = F0
    mem[32'h0007] = 8'h61; mem[32'h0008] = 8'h20; mem[32'h0009] = 8'h21; // add, carry
    mem[32'h000A] = 8'h62; mem[32'h000B] = 8'h05; mem[32'h000C] = 8'h30; // inc, no carry
    mem[32'h000D] = 8'h62; mem[32'h000E] = 8'h20; mem[32'h000F] = 8'h31; // inc, carry
    mem[32'h0010] = 8'hEA;                                              // other opcode
    mem[32'h0011] = 8'h61; mem[32'h0012] = 8'h00; mem[32'h0013] = 8'h40; // add, carry in
    mem[32'h0014] = 8'hEA;
    mem[32'h2015] = 8'h30;
    mem[32'h2110] = 8'h99;   // wrong-page byte, must not be used
    mem[32'h2210] = 8'hE0;
    mem[32'h30F5] = 8'h7F;
    mem[32'h3110] = 8'h55;
    mem[32'h3210] = 8'hFF;
    mem[32'h40F0] = 8'h05;

    epc = 16'h0000; ex = 8'h00; ea = 8'h00; ed = 8'h00; ec = 1'b0; epend = 1'b0;
    do_ldx();
    do_mem(1'b0);
    do_ldx();
    do_mem(1'b0);
    do_mem(1'b1);
    do_mem(1'b1);
    do_nop();
    do_mem(1'b0);
    do_nop();
    do_nop();

    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(mem_we === 1'b0, "R1", "mem_we in reset", mem_we, 0);
    check(mem_addr === 16'h0000, "R1", "mem_addr in reset", mem_addr, 0);
    check(fetch_o === 1'b1, "R1", "fetch_o in reset", fetch_o, 1);
    check(acc_o === 8'h00 && carry_o === 1'b0, "R1", "acc/carry in reset",
          {acc_o, carry_o}, 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    run = 1'b1;
    wait (exp_q.size() == 0);
    @(negedge clk);
    // R8 memory contents after both increments
    check(rd(16'h30F5) === 8'h80, "R8", "inc result same page", rd(16'h30F5), 8'h80);
    check(rd(16'h3210) === 8'h00, "R8", "inc result next page", rd(16'h3210), 8'h00);
    check(rd(16'h3110) === 8'h55, "R8", "wrong page untouched", rd(16'h3110), 8'h55);
    // R6 / R7 final accumulator: 30, then 30+E0 -> 10 c1, then 10+05+1 -> 16 c0
    check(acc_o === 8'h16 && carry_o === 1'b0, "R6", "final acc/carry",
          {acc_o, carry_o}, {8'h16, 1'b0});
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule